// File: doc/BRIEF.md
# Debug Event Pin Output Controller

This block drives four general-purpose debug output pins. Each pin has a two-bit source selector. A pin can be off, it can toggle on hits from its own event-detection channel, it can show whether the core is in debug state (pin index 1 only), or it can show that the host-to-core receive mailbox holds unread data (pin index 3 only). Logic analysers or slow output pads watch the pins. The time between two events shows up as the spacing of the toggle edges.

Output pads may run at a quarter of the core clock or slower, so a pin in event mode never toggles in two consecutive cycles. A hit that arrives in the cycle after a toggle is held as one pending toggle and is applied in the next cycle. Any hits that arrive while a toggle is pending are merged into it. The debug-state flag and the mailbox flag are tracked at all times, whatever the pin modes are. When a pin is switched to one of these sources, it shows the current value of the flag at once.

Top module: `dbg_pin_drive`

## Requirements
- R1: When pin i has mode 01 (event toggle), a hit on evtHit[i] inverts pinOut[i]. The new level appears in the cycle after the clock edge that samples the hit, provided pin i did not toggle at the previous edge.
- R2: A pin in event mode never changes level at two consecutive clock edges.
- R3: A hit that arrives one cycle after a toggle becomes a single pending toggle, which is applied at the next edge. Further hits that arrive while it is pending are merged, so two back-to-back hits give exactly two toggles in total and three give two toggles.
- R4: Mode 00 drives the pin to 0. Mode 10 on any pin other than index 1, and mode 11 on any pin other than index 3, also drive 0. In each of these cases hits have no effect on the pin.
- R5: With mode 10 on pin index 1, pinOut[1] goes to 1 after dbgEnter and to 0 after dbgExit. If both arrive in the same cycle, enter wins.
- R6: With mode 11 on pin index 3, pinOut[3] goes to 1 after mbxHostWr and to 0 after mbxCoreRdHi, the core read of the upper half of the mailbox. If both arrive in the same cycle, the write wins and the pin stays at 1.
- R7: A write that changes a pin's mode discards that pin's pending toggle and drops any hit in the same cycle. From the next cycle the pin shows the new source's current value. The toggle level is kept across mode changes.
- R8: A synchronous active-high rst clears all pin levels, pending toggles, both flags and all mode fields, so pinOut reads 0000 after the reset edge.
- R9: When cfgWe is 1, all mode fields are loaded from cfgData. The field for pin i is cfgData[2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Load all pin mode fields |
| cfgData | input | 8 | Mode fields, two bits per pin |
| evtHit | input | 4 | Per-pin event-detection strobes |
| dbgEnter | input | 1 | Core enters debug state |
| dbgExit | input | 1 | Core leaves debug state |
| mbxHostWr | input | 1 | Host finished writing the receive mailbox |
| mbxCoreRdHi | input | 1 | Core finished reading the mailbox upper half |
| pinOut | output | 4 | Debug pin levels |

## Verification
Several pairs of functions can fall in the same cycle. A new hit can land in the same cycle as a pending toggle, and a mode write can coincide with a pending toggle. A mailbox write can coincide with a core read of the upper half, and a debug entry with a debug exit. Directed sequences place each pair in one cycle and compare the pin levels with literal expected values. Random stimulus then mixes strobes, mode writes and resets, and every cycle's pins are compared with a bench model built from the requirements.

// File: rtl/dbgpin_pkg.sv
package dbgpin_pkg;
  parameter int unsigned PIN_CNT = 4;
  parameter int unsigned MODE_W  = 2;
  parameter int unsigned DBG_PIN = 1;
  parameter int unsigned MBX_PIN = 3;
  localparam int unsigned CFG_W  = PIN_CNT * MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_DBG = 2'b10,
    MODE_MBX = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic [PIN_CNT-1:0] flip;
    logic               dbgSet;
    logic               dbgClr;
    logic               mbxSet;
    logic               mbxClr;
  } pin_strb_t;
endpackage

// File: rtl/dbgpin_ctrl.sv
module dbgpin_ctrl
  import dbgpin_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfgWe,
  input  logic [CFG_W-1:0]                cfgData,
  input  logic [PIN_CNT-1:0]              evtHit,
  input  logic                            dbgEnter,
  input  logic                            dbgExit,
  input  logic                            mbxHostWr,
  input  logic                            mbxCoreRdHi,
  output logic [PIN_CNT-1:0][MODE_W-1:0]  modeQ,
  output pin_strb_t                       strb
);
  logic [PIN_CNT-1:0] pendQ, pendD, lastQ, modeChg, want, isEvt;

  always_comb begin
    strb = '0;
    for (int i = 0; i < PIN_CNT; i++) begin
      modeChg[i]   = cfgWe && (cfgData[i*MODE_W +: MODE_W] != modeQ[i]);
      want[i]      = evtHit[i] | pendQ[i];
      isEvt[i]     = (modeQ[i] == MODE_EVT);
      strb.flip[i] = !rst && !modeChg[i] && isEvt[i] && want[i] && !lastQ[i];
      pendD[i]     = !modeChg[i] && isEvt[i] && want[i] && lastQ[i];
    end
    strb.dbgSet = dbgEnter;
    strb.dbgClr = dbgExit & ~dbgEnter;
    strb.mbxSet = mbxHostWr;
    strb.mbxClr = mbxCoreRdHi & ~mbxHostWr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0;
      pendQ <= '0;
      lastQ <= '0;
    end else begin
      if (cfgWe) begin
        for (int i = 0; i < PIN_CNT; i++)
          modeQ[i] <= cfgData[i*MODE_W +: MODE_W];
      end
      pendQ <= pendD;
      lastQ <= strb.flip;
    end
  end

  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.flip != '0) |=> ((strb.flip & $past(strb.flip)) == '0));

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_chk
    assert_pend_drains_R3: assert property (@(posedge clk) disable iff (rst)
      (pendQ[g] && !modeChg[g]) |-> strb.flip[g]);
    assert_mode_chg_clears_R7: assert property (@(posedge clk) disable iff (rst)
      modeChg[g] |=> !pendQ[g]);
  end
endmodule

// File: rtl/dbgpin_dp.sv
module dbgpin_dp
  import dbgpin_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [PIN_CNT-1:0][MODE_W-1:0]  modeQ,
  input  pin_strb_t                       strb,
  output logic [PIN_CNT-1:0]              pinOut
);
  logic [PIN_CNT-1:0] togLvl;
  logic               dbgState, mbxFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      togLvl   <= '0;
      dbgState <= 1'b0;
      mbxFull  <= 1'b0;
    end else begin
      togLvl <= togLvl ^ strb.flip;
      if (strb.dbgSet)      dbgState <= 1'b1;
      else if (strb.dbgClr) dbgState <= 1'b0;
      if (strb.mbxSet)      mbxFull <= 1'b1;
      else if (strb.mbxClr) mbxFull <= 1'b0;
    end
  end

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
    localparam bit HAS_DBG = (g == DBG_PIN);
    localparam bit HAS_MBX = (g == MBX_PIN);
    always_comb begin
      unique case (pin_mode_e'(modeQ[g]))
        MODE_EVT: pinOut[g] = togLvl[g];
        MODE_DBG: pinOut[g] = HAS_DBG ? dbgState : 1'b0;
        MODE_MBX: pinOut[g] = HAS_MBX ? mbxFull : 1'b0;
        default:  pinOut[g] = 1'b0;
      endcase
    end
    if (!HAS_DBG) begin : g_nodbg
      assert_illegal_dbg_R4: assert property (@(posedge clk) disable iff (rst)
        (modeQ[g] == MODE_DBG) |-> !pinOut[g]);
    end
  end

  assert_toggle_level_R1: assert property (@(posedge clk) disable iff (rst)
    (strb.flip != '0) |=> (togLvl == ($past(togLvl) ^ $past(strb.flip))));
  assert_dbg_enter_R5: assert property (@(posedge clk) disable iff (rst)
    strb.dbgSet |=> dbgState);
  assert_dbg_exit_R5: assert property (@(posedge clk) disable iff (rst)
    strb.dbgClr |=> !dbgState);
  assert_mbx_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
    strb.mbxSet |=> mbxFull);
  assert_mbx_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    strb.mbxClr |=> !mbxFull);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (pinOut == '0));
endmodule

// File: rtl/dbg_pin_drive.sv
module dbg_pin_drive
  import dbgpin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [PIN_CNT-1:0] evtHit,
  input  logic               dbgEnter,
  input  logic               dbgExit,
  input  logic               mbxHostWr,
  input  logic               mbxCoreRdHi,
  output logic [PIN_CNT-1:0] pinOut
);
  logic [PIN_CNT-1:0][MODE_W-1:0] modeQ;
  pin_strb_t                      strb;

  dbgpin_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgData(cfgData), .evtHit(evtHit),
    .dbgEnter(dbgEnter), .dbgExit(dbgExit), .mbxHostWr(mbxHostWr),
    .mbxCoreRdHi(mbxCoreRdHi), .modeQ(modeQ), .strb(strb)
  );

  dbgpin_dp u_dp (
    .clk(clk), .rst(rst), .modeQ(modeQ), .strb(strb), .pinOut(pinOut)
  );
endmodule

// File: tb/dbg_pin_drive_bench.sv
`timescale 1ns/100ps
module dbg_pin_drive_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0;
  logic [7:0] cfgData = '0;
  logic [3:0] evtHit = '0;
  logic dbgEnter = 1'b0, dbgExit = 1'b0, mbxHostWr = 1'b0, mbxCoreRdHi = 1'b0;
  logic [3:0] pinOut;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] mMode [4];
  logic [3:0] mLvl, mPend, mLast;
  logic mDbg, mMbx;

  always #2.5 clk = ~clk;

  dbg_pin_drive u_dbg_pin_drive (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgData(cfgData), .evtHit(evtHit),
    .dbgEnter(dbgEnter), .dbgExit(dbgExit), .mbxHostWr(mbxHostWr),
    .mbxCoreRdHi(mbxCoreRdHi), .pinOut(pinOut)
  );

  function automatic logic [3:0] expPins();
    logic [3:0] e = '0;
    for (int i = 0; i < 4; i++) begin
      case (mMode[i])
        2'b01: e[i] = mLvl[i];
        2'b10: e[i] = (i == 1) ? mDbg : 1'b0;
        2'b11: e[i] = (i == 3) ? mMbx : 1'b0;
        default: e[i] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic modelStep();
    logic [3:0] nL, nP, nT;
    if (rst) begin
      for (int i = 0; i < 4; i++) mMode[i] = 2'b00;
      mLvl = '0; mPend = '0; mLast = '0; mDbg = 1'b0; mMbx = 1'b0;
      return;
    end
    nL = mLvl; nP = '0; nT = '0;
    for (int i = 0; i < 4; i++) begin
      bit chg = cfgWe && (cfgData[2*i +: 2] != mMode[i]);
      bit hit = evtHit[i] || mPend[i];
      if (!chg && mMode[i] == 2'b01 && hit) begin
        if (mLast[i]) nP[i] = 1'b1;
        else begin nL[i] = ~mLvl[i]; nT[i] = 1'b1; end
      end
    end
    mLvl = nL; mPend = nP; mLast = nT;
    if (dbgEnter) mDbg = 1'b1; else if (dbgExit) mDbg = 1'b0;
    if (mbxHostWr) mMbx = 1'b1; else if (mbxCoreRdHi) mMbx = 1'b0;
    if (cfgWe) for (int i = 0; i < 4; i++) mMode[i] = cfgData[2*i +: 2];
  endtask

  task automatic tick(input logic cw, input logic [7:0] cd, input logic [3:0] ev,
                      input logic de, input logic dx, input logic hw, input logic rd);
    @(negedge clk);
    cfgWe = cw; cfgData = cd; evtHit = ev;
    dbgEnter = de; dbgExit = dx; mbxHostWr = hw; mbxCoreRdHi = rd;
    @(posedge clk);
    #1;
    modelStep();
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    total++;
    if (pinOut !== exp) begin
      bad++;
      $display("FAIL %s: pinOut=%b expected=%b", tag, pinOut, exp);
    end
  endtask

  initial begin
    #(200000.0 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    tick(0, 8'h00, 4'h0, 0, 0, 0, 0);
    tick(0, 8'h00, 4'h0, 0, 0, 0, 0);
    rst = 1'b0;
    chk("R8 reset state", 4'b0000);
    tick(1, 8'b01010101, 4'h0, 0, 0, 0, 0);
    chk("R9 all event mode", 4'b0000);
    tick(0, 8'h00, 4'b0001, 0, 0, 0, 0);
    chk("R1 single hit", 4'b0001);
    tick(0, 8'h00, 4'b0100, 0, 0, 0, 0);
    chk("R1 hit pin2", 4'b0101);
    tick(0, 8'h00, 4'b0100, 0, 0, 0, 0);
    chk("R2 blocked back-to-back", 4'b0101);
    tick(0, 8'h00, 4'b0000, 0, 0, 0, 0);
    chk("R3 pending applied", 4'b0001);
    tick(0, 8'h00, 4'b0001, 0, 0, 0, 0);
    chk("R1 pin0 back to 0", 4'b0000);
    tick(0, 8'h00, 4'b0001, 0, 0, 0, 0);
    chk("R2 pin0 blocked", 4'b0000);
    tick(0, 8'h00, 4'b0001, 0, 0, 0, 0);
    chk("R3 merged toggle", 4'b0001);
    tick(0, 8'h00, 4'b0000, 0, 0, 0, 0);
    chk("R3 no extra toggle", 4'b0001);
    tick(0, 8'h00, 4'b0100, 0, 0, 0, 0);
    chk("R1 pin2 up", 4'b0101);
    tick(0, 8'h00, 4'b0100, 0, 0, 0, 0);
    chk("R2 pin2 blocked", 4'b0101);
    tick(1, 8'b01000101, 4'b0100, 0, 0, 0, 0);
    chk("R7 switched off", 4'b0001);
    tick(1, 8'b01010101, 4'b0000, 0, 0, 0, 0);
    chk("R7 level kept", 4'b0101);
    tick(0, 8'h00, 4'b0000, 0, 0, 0, 0);
    chk("R7 pending discarded", 4'b0101);
    tick(1, 8'b01011001, 4'b0000, 0, 0, 0, 0);
    chk("R5 debug source idle", 4'b0101);
    tick(0, 8'h00, 4'b0000, 1, 0, 0, 0);
    chk("R5 enter", 4'b0111);
    tick(0, 8'h00, 4'b0000, 1, 1, 0, 0);
    chk("R5 enter wins", 4'b0111);
    tick(0, 8'h00, 4'b0000, 0, 1, 0, 0);
    chk("R5 exit", 4'b0101);
    tick(1, 8'b11011001, 4'b0000, 0, 0, 0, 0);
    chk("R6 mailbox idle", 4'b0101);
    tick(0, 8'h00, 4'b0000, 0, 0, 1, 0);
    chk("R6 host write", 4'b1101);
    tick(0, 8'h00, 4'b0000, 0, 0, 1, 1);
    chk("R6 write wins", 4'b1101);
    tick(0, 8'h00, 4'b0000, 0, 0, 0, 1);
    chk("R6 core read", 4'b0101);
    tick(1, 8'b11111010, 4'b0101, 1, 0, 1, 0);
    chk("R4 illegal modes drive 0", 4'b1010);
    tick(1, 8'b00000000, 4'b1111, 0, 0, 0, 0);
    chk("R4 off mode", 4'b0000);
    tick(0, 8'h00, 4'b1111, 0, 0, 0, 0);
    chk("R4 hits ignored", 4'b0000);
    rst = 1'b1;
    tick(1, 8'b11011001, 4'b1111, 1, 0, 1, 0);
    rst = 1'b0;
    chk("R8 reset mid-run", 4'b0000);
    chk("R8 model agrees", expPins());

    for (int n = 0; n < 4000; n++) begin
      logic cw;
      cw  = ($urandom % 16) == 0;
      rst = ($urandom % 300) == 0;
      tick(cw, 8'($urandom), 4'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 6) == 0, ($urandom % 6) == 0);
      chk("R2 random vs model", expPins());
    end
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule